// File: doc/BRIEF.md
# Conversion Rate Scheduler with Oversampling

This block paces temperature measurements. A free-running timebase tick is counted down to issue conversion start strobes toward an external converter. The 11-bit raw readings that come back are summed, and one averaged result is reported per conversion. A 2-bit rate code selects 1, 2, 4 or 8 conversions per second. When dynamic averaging is active, slower rates average more readings, so the converter is strobed at the same pace in every rate. A disable bit turns this off and gives one reading per result.

One conversion period is split into as many equal slots as the current averaging factor. Each slot opens with a start strobe. Rate and disable settings are taken only at a conversion boundary. A conversion that has not collected all of its readings by the next boundary is dropped. The averaged value is the sum shifted right by log2 of the factor. A single-cycle valid pulse marks each result.

The parameter `TICKS_PER_SEC` gives the number of timebase ticks in one second. It must be a multiple of 8 and at least 16, so every slot is at least two ticks long.

Top module: `conv_rate_sched`

## Requirements
- R1: A start strobe is a one-cycle pulse, one cycle after a counted tick. With rate code c and averaging shift s, consecutive strobes are `TICKS_PER_SEC >> (c + s)` ticks apart. A conversion spans `TICKS_PER_SEC >> c` ticks.
- R2: With `dynDis` = 0, the averaging shift is 3 − c. Code 00 averages 8 readings, 01 averages 4, 10 averages 2 and 11 averages 1. The rates are 1, 2, 4 and 8 per second.
- R3: With `dynDis` = 1, every rate code uses a factor of 1. There is one strobe and one result per conversion.
- R4: The result is floor(sum of the conversion's readings / factor), 11 bits wide. The 14-bit sum cannot wrap, so 8 readings of 2047 give 2047.
- R5: `resultValid` is high for exactly one cycle, the cycle after the reading that completes the conversion is accepted.
- R6: `rateCode` and `dynDis` are sampled only on the tick that opens a conversion. Changes between boundaries do not affect the conversion in progress.
- R7: A conversion still short of readings at the next boundary is discarded without a result. The new conversion starts from an empty sum.
- R8: A reading is ignored in three cases: before the first boundary, after the conversion already has its full count, and in the boundary cycle itself. Ignored readings produce no result.
- R9: While `enable` is low there are no strobes and no results, and all progress is cleared. The first tick after `enable` rises opens a new conversion.
- R10: After reset, `startStrobe`, `resultValid` and `result` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; low clears and halts scheduling |
| tick | input | 1 | Timebase tick, one cycle per tick |
| rateCode | input | 2 | Conversion rate select, 00..11 = 1, 2, 4, 8 per second |
| dynDis | input | 1 | 1 forces single-reading results |
| sampleValid | input | 1 | Raw reading present |
| sampleData | input | 11 | Raw reading |
| startStrobe | output | 1 | Conversion start request to the converter |
| result | output | 11 | Averaged result |
| resultValid | output | 1 | One-cycle pulse marking a new result |

## Verification
The hardest case to reach is a conversion boundary arriving while a sum is only partly collected, combined with a rate change pending at that same boundary. The stimulus gets there with a converter model that withholds readings, either all of them or at random. Settings are changed at random cycles, so they often land in the middle of a conversion. Stray readings are injected outside slots to cover the ignore cases. A cycle-level reference model built from the requirements predicts every strobe and every result.

// File: rtl/convsched_pkg.sv
package convsched_pkg;

  // Strobes and settings passed from control to datapath
  typedef struct packed {
    logic       convStart;   // tick that opens a new conversion
    logic [1:0] shiftAmt;    // log2 of averaging factor of current conversion
  } ctlStrobes_t;

  // Averaging shift for a rate code: slower rates average more readings
  function automatic logic [1:0] factorShift(input logic [1:0] rate, input logic dis);
    return dis ? 2'd0 : 2'd3 - rate;
  endfunction

endpackage

// File: rtl/convsched_ctrl.sv
module convsched_ctrl
  import convsched_pkg::*;
#(
  parameter int TICKS_PER_SEC = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        tick,
  input  logic [1:0]  rateCode,
  input  logic        dynDis,
  output logic        startStrobe,
  output ctlStrobes_t ctl
);
  localparam int TICK_W = $clog2(TICKS_PER_SEC);

  logic [TICK_W-1:0] tickCnt;
  logic [TICK_W-1:0] slotLast;
  logic [2:0]        slotIdx;
  logic [2:0]        idxLast;
  logic [1:0]        curRate;
  logic              curDis;
  logic [1:0]        curShift;
  logic              convStart;

  always_comb begin
    curShift  = factorShift(curRate, curDis);
    slotLast  = TICK_W'((TICKS_PER_SEC >> (32'(curRate) + 32'(curShift))) - 1);
    idxLast   = 3'((4'd1 << curShift) - 4'd1);
    convStart = tick && enable && (tickCnt == '0) && (slotIdx == 3'd0);
  end

  assign ctl.convStart = convStart;
  assign ctl.shiftAmt  = curShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt     <= '0;
      slotIdx     <= 3'd0;
      curRate     <= 2'b10;
      curDis      <= 1'b0;
      startStrobe <= 1'b0;
    end else if (!enable) begin
      tickCnt     <= '0;
      slotIdx     <= 3'd0;
      startStrobe <= 1'b0;
    end else begin
      startStrobe <= tick && (tickCnt == '0);
      if (convStart) begin
        curRate <= rateCode;
        curDis  <= dynDis;
      end
      if (tick) begin
        // slotLast >= 1, so a boundary tick (tickCnt == 0) never wraps here
        if (tickCnt == slotLast) begin
          tickCnt <= '0;
          slotIdx <= (slotIdx == idxLast) ? 3'd0 : slotIdx + 3'd1;
        end else begin
          tickCnt <= tickCnt + TICK_W'(1);
        end
      end
    end
  end

  initial assert (TICKS_PER_SEC >= 16 && TICKS_PER_SEC % 8 == 0)
    else $error("TICKS_PER_SEC must be a multiple of 8 and at least 16");

  // R1: every strobe follows a tick by one cycle and lasts one cycle
  a_r1_strobe_after_tick: assert property (@(posedge clk) disable iff (!rstN)
    startStrobe |-> $past(tick) && $past(enable));
  a_r1_strobe_single: assert property (@(posedge clk) disable iff (!rstN)
    startStrobe |=> !startStrobe);
  // R6: settings only move at a conversion boundary
  a_r6_settings_held: assert property (@(posedge clk) disable iff (!rstN)
    !convStart |=> $stable(curRate) && $stable(curDis));
  // R9: disabled means no strobes
  a_r9_no_strobe_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !startStrobe);
endmodule

// File: rtl/convsched_datapath.sv
module convsched_datapath
  import convsched_pkg::*;
#(
  parameter int SAMPLE_W = 11
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  ctlStrobes_t         ctl,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  output logic [SAMPLE_W-1:0] result,
  output logic                resultValid
);
  localparam int ACC_W = SAMPLE_W + 3;

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] accNext;
  logic [3:0]       cnt;
  logic [3:0]       cntNext;
  logic [3:0]       factor;
  logic             active;
  logic             full;
  logic             take;

  always_comb begin
    factor  = 4'd1 << ctl.shiftAmt;
    accNext = acc + ACC_W'(sampleData);
    cntNext = cnt + 4'd1;
    take    = sampleValid && active && !full && !ctl.convStart;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc <= '0; cnt <= 4'd0; active <= 1'b0; full <= 1'b0;
      result <= '0; resultValid <= 1'b0;
    end else if (!enable) begin
      acc <= '0; cnt <= 4'd0; active <= 1'b0; full <= 1'b0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= 1'b0;
      if (ctl.convStart) begin
        acc <= '0; cnt <= 4'd0; full <= 1'b0; active <= 1'b1;
      end else if (take) begin
        if (cntNext == factor) begin
          result      <= SAMPLE_W'(accNext >> ctl.shiftAmt);
          resultValid <= 1'b1;
          full        <= 1'b1;
          acc         <= '0;
          cnt         <= 4'd0;
        end else begin
          acc <= accNext;
          cnt <= cntNext;
        end
      end
    end
  end

  // R4: the sum never wraps
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    take |-> accNext >= acc);
  // R8: collected count stays below the factor
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    cnt < factor);
  // R5: valid is a single-cycle pulse
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);
  // R9: no result while disabled
  a_r9_no_result_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !resultValid);
endmodule

// File: rtl/conv_rate_sched.sv
module conv_rate_sched
  import convsched_pkg::*;
#(
  parameter int TICKS_PER_SEC = 16,
  parameter int SAMPLE_W      = 11
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic                tick,
  input  logic [1:0]          rateCode,
  input  logic                dynDis,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  output logic                startStrobe,
  output logic [SAMPLE_W-1:0] result,
  output logic                resultValid
);
  ctlStrobes_t ctl;

  convsched_ctrl #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .tick(tick),
    .rateCode(rateCode), .dynDis(dynDis),
    .startStrobe(startStrobe), .ctl(ctl)
  );

  convsched_datapath #(.SAMPLE_W(SAMPLE_W)) u_dp (
    .clk(clk), .rstN(rstN), .enable(enable), .ctl(ctl),
    .sampleValid(sampleValid), .sampleData(sampleData),
    .result(result), .resultValid(resultValid)
  );
endmodule

// File: tb/conv_rate_sched_tb.sv
module conv_rate_sched_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TPS = 16;

  logic clk = 0, rstN = 0, enable = 0, tick = 0, dynDis = 0;
  logic [1:0] rateCode = 2'b10;
  logic sampleValid = 0;
  logic [10:0] sampleData = 0;
  logic startStrobe, resultValid;
  logic [10:0] result;

  conv_rate_sched #(.TICKS_PER_SEC(TPS), .SAMPLE_W(11)) u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  int tickDiv = 4, dropMode = 0, spurMode = 0, dataMode = 0;
  bit checking = 0;
  string curTag = "R2";
  int obsStrobes = 0, obsResults = 0, modelDiscards = 0;
  int lastResult = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int shiftOf(input int rate, input int dis);
    return dis ? 0 : 3 - rate;
  endfunction

  function automatic int slotTicksOf(input int rate, input int sh);
    return TPS >> (rate + sh);
  endfunction

  // timebase tick and converter model (drive after posedge)
  int tcnt = 0;
  bit d1 = 0, d2 = 0;
  always begin
    @(posedge clk); #1;
    tick = (tcnt == 0) && rstN;
    tcnt = (tcnt >= tickDiv - 1) ? 0 : tcnt + 1;
    d2 = d1; d1 = startStrobe;
    sampleValid = 0;
    if (d2 && (dropMode == 0 || (dropMode == 2 && ($urandom % 4) != 0))) sampleValid = 1;
    if (spurMode != 0 && ($urandom % 9) == 0) sampleValid = 1;
    case (dataMode)
      1: sampleData = 11'h7FF;
      2: sampleData = 11'h000;
      default: sampleData = 11'($urandom);
    endcase
  end

  // reference model and checks at negedge
  bit expStrobe = 0, expValid = 0;
  int expResult = 0;
  int mCnt = 0, mSlot = 0, mShift = 1, mLast = 1, mAcc = 0, mN = 0;
  bit mActive = 0, mFull = 0;
  always @(negedge clk) begin
    if (checking) begin
      chk(startStrobe == expStrobe, "R1 strobe timing", int'(startStrobe), int'(expStrobe));
      chk(resultValid == expValid, {"R5 valid pulse/", curTag}, int'(resultValid), int'(expValid));
      if (expValid)
        chk(int'(result) == expResult, {"R4 averaged value/", curTag}, int'(result), expResult);
    end
    if (startStrobe) obsStrobes++;
    if (resultValid) begin obsResults++; lastResult = int'(result); end
    expStrobe = 0; expValid = 0;
    if (!rstN || !enable) begin
      mCnt = 0; mSlot = 0; mActive = 0; mAcc = 0; mN = 0; mFull = 0;
    end else begin
      automatic bit bnd = tick && mCnt == 0 && mSlot == 0;
      if (sampleValid && mActive && !mFull && !bnd) begin
        mAcc += int'(sampleData); mN++;
        if (mN == (1 << mShift)) begin
          expValid = 1; expResult = mAcc >> mShift;
          mFull = 1; mAcc = 0; mN = 0;
        end
      end
      if (tick) begin
        if (mCnt == 0) expStrobe = 1;
        if (bnd) begin
          if (mActive && !mFull) modelDiscards++;
          mShift = shiftOf(int'(rateCode), int'(dynDis));
          mLast = slotTicksOf(int'(rateCode), mShift) - 1;
          mAcc = 0; mN = 0; mFull = 0; mActive = 1;
        end
        if (mCnt == mLast) begin
          mCnt = 0;
          mSlot = (mSlot == (1 << mShift) - 1) ? 0 : mSlot + 1;
        end else mCnt++;
      end
    end
  end

  task automatic runCycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // settle, then measure strobes per result against factor (R2 / R3)
  task automatic ratioPhase(input int rate, input int dis, input string tag);
    int s0, r0, s, r, f;
    rateCode = 2'(rate); dynDis = dis[0]; curTag = tag;
    runCycles(150);
    s0 = obsStrobes; r0 = obsResults;
    runCycles(400);
    s = obsStrobes - s0; r = obsResults - r0; f = 1 << shiftOf(rate, dis);
    chk(r >= 1, {tag, " results produced"}, r, 1);
    chk(s >= f * (r - 1) && s <= f * (r + 1), {tag, " strobes per result"}, s, f * r);
  endtask

  initial begin
    int s0, r0, d0;
    void'($urandom(32'h5EED));
    runCycles(5);
    chk(startStrobe == 0, "R10 reset strobe", int'(startStrobe), 0);
    chk(resultValid == 0, "R10 reset valid", int'(resultValid), 0);
    chk(result == 0, "R10 reset result", int'(result), 0);
    rstN = 1; checking = 1;
    runCycles(3);
    chk(startStrobe == 0 && obsStrobes == 0, "R9 no strobe before enable", obsStrobes, 0);
    enable = 1;

    for (int rc = 0; rc < 4; rc++) ratioPhase(rc, 0, "R2");
    for (int rc = 0; rc < 4; rc++) ratioPhase(rc, 1, "R3");

    // overflow corner: 8 readings of full scale, then zeros
    dataMode = 1; rateCode = 2'b00; dynDis = 0; curTag = "R4";
    runCycles(300);
    chk(lastResult == 2047, "R4 full-scale x8 average", lastResult, 2047);
    dataMode = 2; runCycles(300);
    chk(lastResult == 0, "R4 zero average", lastResult, 0);
    dataMode = 0;

    // all readings withheld: every conversion is discarded
    curTag = "R7"; dropMode = 1;
    r0 = obsResults; d0 = modelDiscards; runCycles(400);
    chk(obsResults == r0, "R7 no result when readings missing", obsResults - r0, 0);
    chk(modelDiscards > d0, "R7 discards occurred", modelDiscards - d0, 1);
    dropMode = 2; runCycles(600); dropMode = 0;

    // stray readings
    curTag = "R8"; spurMode = 1; rateCode = 2'b01; runCycles(800); spurMode = 0;

    // disable window
    curTag = "R9"; enable = 0;
    s0 = obsStrobes; r0 = obsResults; runCycles(200);
    chk(obsStrobes == s0, "R9 no strobes while disabled", obsStrobes - s0, 0);
    chk(obsResults == r0, "R9 no results while disabled", obsResults - r0, 0);
    enable = 1; runCycles(300);
    chk(obsResults > r0, "R9 results resume after enable", obsResults - r0, 1);

    // random: settings changed mid-conversion, varied tick spacing
    curTag = "R6";
    for (int i = 0; i < 60; i++) begin
      rateCode = 2'($urandom); dynDis = ($urandom % 3) == 0;
      tickDiv = 4 + ($urandom % 4);
      spurMode = ($urandom % 4) == 0;
      dropMode = (($urandom % 6) == 0) ? 2 : 0;
      runCycles(50 + ($urandom % 250));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule